// File: doc/BRIEF.md
# Superset Filter Shift Window

This block thins a stream of feature subsets, each coded as a W-bit mask in which a set bit marks a member. A subset arriving with its valid strobe is compared in the same cycle against every entry of a short window of subsets that were recently let through. If the arrival contains every member of at least one stored entry, it cannot be minimal and is dropped without a trace. Otherwise it is emitted one cycle later on the output, with its own valid flag, and is also pushed into the head of the window.

The window is a chain of DEPTH registers. A push moves each entry one step towards the tail, and the entry at the tail is lost, so the window always keeps the DEPTH most recent survivors. After reset every entry holds the all-ones mask. The filter is lossy on purpose: a non-minimal subset whose smaller partner has already left the window gets through, and a stage further downstream finishes the job. The block takes a new subset on every clock cycle and never stalls.

Top module: `subset_window_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_set` is all zeros.
- R2: An all-ones input mask never produces an output, because it contains every mask held in the window, the all-ones reset entries among them.
- R3: An input mask M is dropped (no `out_valid` in the next cycle) when, for some window entry S, (S AND M) equals S; an input equal to a stored entry counts as contained and is dropped.
- R4: An input mask that contains no window entry raises `out_valid` for exactly the next cycle, with `out_set` equal to that mask.
- R5: Each forwarded mask enters the window head and the others move one step; after DEPTH further forwarded masks it has left the window and no longer causes drops.
- R6: Inputs may arrive on consecutive cycles; each one is judged against a window that already includes the mask forwarded in the previous cycle.
- R7: A cycle with `in_valid` low produces no output and leaves the window unchanged, whatever `in_set` holds.
- R8: When `out_valid` is low, `out_set` keeps the last forwarded mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input mask is presented this cycle |
| in_set | input | W | Input subset mask |
| out_valid | output | 1 | `out_set` holds a forwarded mask this cycle |
| out_set | output | W | Last forwarded subset mask |

## Verification
The bench builds the filter with W = 4 and DEPTH = 3. With only sixteen masks and a three-entry window, it can run every ordered pair of masks from reset, along with full ascending, descending and strided sweeps, both back to back and with idle gaps. At this depth eviction shows up within a few pushes, so the point where a dropped mask becomes admissible again can be checked directly. A bench model of the same window supplies every expected decision.

// File: rtl/subset_window_filter.sv
module subset_window_filter #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_set,
  output logic         out_valid,
  output logic [W-1:0] out_set
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0]     win [DEPTH];
  logic [DEPTH-1:0] covered;
  logic             push;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    assign covered[g] = ((win[g] & in_set) == win[g]);

    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)    win[g] <= ALL_ONES;
        else if (push) win[g] <= in_set;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)    win[g] <= ALL_ONES;
        else if (push) win[g] <= win[g-1];
      end
    end
  end

  assign push = in_valid && (covered == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_set   <= '0;
    end else begin
      out_valid <= push;
      if (push) out_set <= in_set;
    end
  end

endmodule

// File: rtl/subset_window_filter_chk.sv
module subset_window_filter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_set,
  input logic         out_valid,
  input logic [W-1:0] out_set
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_set == '0));

  assert_full_mask_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_set == {W{1'b1}}) |=> !out_valid);

  assert_repeat_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_valid && in_set == out_set) |=> !out_valid);

  assert_forward_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && out_set == $past(in_set)));

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> $stable(out_set));

endmodule

bind subset_window_filter subset_window_filter_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_set(in_set),
  .out_valid(out_valid), .out_set(out_set)
);

// File: tb/test_subset_window_filter.sv
`timescale 1ns/1ps
module test_subset_window_filter;
  localparam int W = 4;
  localparam int DEPTH = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_set = '0;
  logic         out_valid;
  logic [W-1:0] out_set;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_win [DEPTH];
  logic [W-1:0] m_last;

  always #2.5 clk = ~clk;

  subset_window_filter #(.W(W), .DEPTH(DEPTH)) i_subset_window_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_set(in_set),
    .out_valid(out_valid), .out_set(out_set)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic model_pass(input logic [W-1:0] m);
    for (int i = 0; i < DEPTH; i++)
      if ((m_win[i] & m) == m_win[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_set = '0;
    @(negedge clk);
    check("R1 valid", {3'b0, out_valid}, 4'h0);
    check("R1 data", out_set, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", {3'b0, out_valid}, 4'h0);
    for (int i = 0; i < DEPTH; i++) m_win[i] = '1;
    m_last = '0;
  endtask

  // Drives one cycle (at negedge) and checks the registered result one cycle later.
  task automatic step(input logic v, input logic [W-1:0] m, input string tag);
    logic exp;
    exp = v && model_pass(m);
    in_valid = v; in_set = m;
    @(negedge clk);
    if (!v)             check({tag, " R7 idle"}, {3'b0, out_valid}, 4'h0);
    else if (m == '1)   check({tag, " R2 full"}, {3'b0, out_valid}, 4'h0);
    else if (!exp)      check({tag, " R3 drop"}, {3'b0, out_valid}, 4'h0);
    else                check({tag, " R4 fwd"}, {3'b0, out_valid}, 4'h1);
    if (exp) begin
      check({tag, " R4 data"}, out_set, m);
      for (int i = DEPTH-1; i > 0; i--) m_win[i] = m_win[i-1];
      m_win[0] = m;
      m_last = m;
    end else begin
      check({tag, " R8 hold"}, out_set, m_last);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R6: back-to-back ascending and descending sweeps
    for (int v = 0; v < 16; v++) step(1'b1, v[W-1:0], "R6 asc");
    do_reset();
    for (int v = 15; v >= 0; v--) step(1'b1, v[W-1:0], "R6 desc");
    do_reset();
    // R7: strided sweep with idle cycles carrying junk
    for (int v = 0; v < 16; v++) begin
      step(1'b1, 4'((v * 7 + 3) % 16), "stride");
      step(1'b0, 4'(v), "gap");
    end
    // R5: eviction after DEPTH further pushes
    do_reset();
    step(1'b1, 4'b0001, "R5 seed");
    step(1'b1, 4'b0011, "R5 early");
    step(1'b1, 4'b0010, "R5 p1");
    step(1'b1, 4'b0100, "R5 p2");
    step(1'b1, 4'b1000, "R5 p3");
    step(1'b1, 4'b0001, "R5 readmit");
    check("R5 readmit seen", out_set, 4'b0001);
    // R7: idle cycles leave window intact
    do_reset();
    step(1'b1, 4'b0110, "R7 seed");
    for (int i = 0; i < 4; i++) step(1'b0, 4'b1001, "R7 junk");
    step(1'b1, 4'b0111, "R7 still held");
    // all ordered pairs from reset
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        do_reset();
        step(1'b1, a[W-1:0], "pair a");
        step(1'b1, b[W-1:0], "pair b R3");
      end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule